// File: doc/BRIEF.md
# Per-Lane Event Counter Unit

This block counts occurrences of one chosen link-layer or transaction-layer event on one chosen lane of a multi-lane link. Every lane delivers two pulse vectors each cycle: one with a bit per data-link-layer packet event and one with a bit per transaction-layer packet type, for both directions. Software writes a control word that names a group, an event inside that group and a lane. The same word carries a command that switches counting on or off and a command that zeroes the count. A second register returns the running count.

The count is never zeroed by the block on its own. It only restarts on an explicit clear command. When it reaches its maximum it rolls over to zero, and no other signal reports the rollover. A lane index at or above the configured lane count, or a group and event pair with no wired source, selects nothing, so the count stays where it is.

Top module: `lane_event_counter`

## Requirements
- R1: After reset the control register (offset 0x08) and the count register (offset 0x0C) both read 0. Counting is off and the selection is group 0, event 0, lane 0.
- R2: A write to offset 0x08 stores the group from bits 27:24, the event from bits 23:16 and the lane from bits 11:8. Reads return these fields at the same positions. Bits 4:0 and all other unused bits read as 0.
- R3: A control write whose bits 4:2 hold 3 turns counting on, and one whose bits 4:2 hold 1 turns it off. Any other value in bits 4:2 leaves the on/off state as it was. Bit 7 of the control register reads 1 exactly while counting is on.
- R4: While counting is on, each cycle in which the selected pulse is high adds one to the count. The new value is visible from the following cycle at offset 0x0C, zero-extended to 32 bits.
- R5: Group 6 selects the link-layer vector, events 0 to 6, at bit lane*7+event. Group 7 selects the transaction-layer vector, events 0 to 23 (0x17), at bit lane*24+event.
- R6: Pulses on other lanes, other events or the other vector leave the count unchanged. So does any selection whose group is not 6 or 7, or whose event number is beyond the group's range.
- R7: A lane index equal to or greater than NUM_LANES never matches, even when every pulse input is high.
- R8: A control write with bits 1:0 equal to 1 zeroes the count. Other values in bits 1:0 do not. Turning counting off keeps the count.
- R9: When a clear write and a selected pulse fall in the same cycle, the count afterwards is 0.
- R10: The count rolls over from 2^CNT_W-1 to 0 and then keeps counting.
- R11: Reads of any offset other than 0x08 and 0x0C return 0. Writes to other offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| dllpEvt | input | NUM_LANES*7 | Link-layer event pulses, bit lane*7+event |
| tlpEvt | input | NUM_LANES*24 | Transaction-layer event pulses, bit lane*24+event |

## Verification
The bench builds the block with NUM_LANES=3 and CNT_W=8. Three lanes leave lane indices 3 to 15 free in the 4-bit lane field, so the never-matching lane case can be driven while every pulse input is held high. An 8-bit count reaches its rollover after 256 pulses, which makes the wrap test short. The clear-against-pulse collision and the ignored command codes are checked through the count and status read back over the register port.

// File: rtl/lec_pkg.sv
package lec_pkg;

  localparam int REG_W      = 32;
  localparam int OFS_CTRL   = 8'h08;
  localparam int OFS_COUNT  = 8'h0C;
  localparam int GRP_LINK   = 6;
  localparam int GRP_TRANS  = 7;
  localparam int LINK_EVTS  = 7;
  localparam int TRANS_EVTS = 24;
  localparam logic [2:0] RUN_ON  = 3'd3;
  localparam logic [2:0] RUN_OFF = 3'd1;
  localparam logic [1:0] ZERO_CMD = 2'd1;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] evt;
    logic [3:0] lane;
  } lecSel_t;

  typedef struct packed {
    logic clearCnt;
    logic countOn;
  } lecStrobe_t;

endpackage

// File: rtl/lec_ctrl.sv
module lec_ctrl
  import lec_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output lecSel_t           selQ,
  output lecStrobe_t        strb,
  output logic [REG_W-1:0]  ctrlView
);

  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(OFS_CTRL);

  logic       ctrlWr;
  logic       runQ;
  logic [2:0] runCmd;
  logic [1:0] zeroCmd;

  assign ctrlWr  = regWrEn && (regAddr == CtrlAddr);
  assign runCmd  = regWrData[4:2];
  assign zeroCmd = regWrData[1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      runQ <= 1'b0;
    end else if (ctrlWr) begin
      selQ.grp  <= regWrData[27:24];
      selQ.evt  <= regWrData[23:16];
      selQ.lane <= regWrData[11:8];
      if (runCmd == RUN_ON)       runQ <= 1'b1;
      else if (runCmd == RUN_OFF) runQ <= 1'b0;
    end
  end

  always_comb begin
    strb.clearCnt = ctrlWr && (zeroCmd == ZERO_CMD);
    strb.countOn  = runQ;
  end

  always_comb begin
    ctrlView        = '0;
    ctrlView[27:24] = selQ.grp;
    ctrlView[23:16] = selQ.evt;
    ctrlView[11:8]  = selQ.lane;
    ctrlView[7]     = runQ;
  end

endmodule

// File: rtl/lec_event_mux.sv
module lec_event_mux
  import lec_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  lecSel_t                           sel,
  input  logic [NUM_LANES*LINK_EVTS-1:0]    dllpEvt,
  input  logic [NUM_LANES*TRANS_EVTS-1:0]   tlpEvt,
  output logic                              hit
);

  localparam int LinkBits  = NUM_LANES * LINK_EVTS;
  localparam int TransBits = NUM_LANES * TRANS_EVTS;

  logic [NUM_LANES-1:0] laneMatch;
  logic [LinkBits-1:0]  linkTerm;
  logic [TransBits-1:0] transTerm;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign laneMatch[l] = (sel.lane == 4'(l));
    for (genvar e = 0; e < LINK_EVTS; e++) begin : g_link
      assign linkTerm[l*LINK_EVTS+e] =
        laneMatch[l] && (sel.evt == 8'(e)) && dllpEvt[l*LINK_EVTS+e];
    end
    for (genvar e = 0; e < TRANS_EVTS; e++) begin : g_trans
      assign transTerm[l*TRANS_EVTS+e] =
        laneMatch[l] && (sel.evt == 8'(e)) && tlpEvt[l*TRANS_EVTS+e];
    end
  end

  always_comb begin
    hit = 1'b0;
    if (sel.grp == 4'(GRP_LINK))  hit = |linkTerm;
    if (sel.grp == 4'(GRP_TRANS)) hit = |transTerm;
  end

endmodule

// File: rtl/lec_counter.sv
module lec_counter
  import lec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  lecStrobe_t       strb,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rstN)                      cnt <= '0;
    else if (strb.clearCnt)         cnt <= '0;
    else if (strb.countOn && hit)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/lane_event_counter.sv
module lane_event_counter
  import lec_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            regWrEn,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [REG_W-1:0]                regWrData,
  output logic [REG_W-1:0]                regRdData,
  input  logic [NUM_LANES*LINK_EVTS-1:0]  dllpEvt,
  input  logic [NUM_LANES*TRANS_EVTS-1:0] tlpEvt
);

  localparam logic [ADDR_W-1:0] CtrlAddr  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] CountAddr = ADDR_W'(OFS_COUNT);

  lecSel_t          selQ;
  lecStrobe_t       strb;
  logic [REG_W-1:0] ctrlView;
  logic             hitPulse;
  logic             countOn;
  logic [CNT_W-1:0] cntVal;
  logic [REG_W-1:0] cntExt;

  lec_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .selQ(selQ), .strb(strb), .ctrlView(ctrlView)
  );

  lec_event_mux #(.NUM_LANES(NUM_LANES)) mux_i (
    .sel(selQ), .dllpEvt(dllpEvt), .tlpEvt(tlpEvt), .hit(hitPulse)
  );

  lec_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hit(hitPulse), .cnt(cntVal)
  );

  assign countOn = strb.countOn;

  always_comb begin
    cntExt              = '0;
    cntExt[CNT_W-1:0]   = cntVal;
    regRdData           = '0;
    if (regAddr == CtrlAddr)  regRdData = ctrlView;
    if (regAddr == CountAddr) regRdData = cntExt;
  end

endmodule

// File: rtl/lec_checker.sv
module lec_checker #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [CNT_W-1:0]  cntVal,
  input logic              countOn,
  input logic              hit
);

  logic ctrlWr;
  logic clrWr;
  assign ctrlWr = regWrEn && (regAddr == ADDR_W'(8'h08));
  assign clrWr  = ctrlWr && (regWrData[1:0] == 2'd1);

  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> (cntVal == '0));

  a_r9_clear_beats_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && countOn && hit) |=> (cntVal == '0));

  a_r4_hit_increments: assert property (@(posedge clk) disable iff (!rstN)
    (countOn && hit && !clrWr) |=> (cntVal == CNT_W'($past(cntVal) + 1'b1)));

  a_r3_off_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!countOn && !clrWr) |=> $stable(cntVal));

  a_r3_run_on: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[4:2] == 3'd3) |=> countOn);

  a_r3_run_off: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[4:2] == 3'd1) |=> !countOn);

  a_r3_other_cmd_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[4:2] != 3'd1 && regWrData[4:2] != 3'd3) |=> $stable(countOn));

endmodule

bind lane_event_counter lec_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .cntVal(cntVal), .countOn(countOn), .hit(hitPulse)
);

// File: tb/lane_event_counter_tb_top.sv
module lane_event_counter_tb_top;

  localparam int LANES  = 3;
  localparam int CW     = 8;
  localparam int AW     = 8;
  localparam int LBITS  = LANES * 7;
  localparam int TBITS  = LANES * 24;
  localparam time CLK_PER = 20ns;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [AW-1:0]    regAddr = '0;
  logic [31:0]      regWrData = '0;
  logic [31:0]      regRdData;
  logic [LBITS-1:0] dllpEvt = '0;
  logic [TBITS-1:0] tlpEvt = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];
  item_t cur;
  event sampleEv;

  always #(CLK_PER/2) clk = ~clk;

  lane_event_counter #(.NUM_LANES(LANES), .CNT_W(CW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .dllpEvt(dllpEvt), .tlpEvt(tlpEvt)
  );

  // monitor: pops expected items and compares with the read port
  initial begin
    forever begin
      @(sampleEv);
      cur = expQ.pop_front();
      checks++;
      if (regRdData !== cur.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", cur.tag, regRdData, cur.exp);
      end
    end
  end

  function automatic logic [31:0] ctl(int g, int e, int l, int run, int clr);
    logic [31:0] w = '0;
    w[27:24] = 4'(g);
    w[23:16] = 8'(e);
    w[11:8]  = 4'(l);
    w[4:2]   = 3'(run);
    w[1:0]   = 2'(clr);
    return w;
  endfunction

  function automatic logic [31:0] view(int g, int e, int l, bit on);
    logic [31:0] w = '0;
    w[27:24] = 4'(g);
    w[23:16] = 8'(e);
    w[11:8]  = 4'(l);
    w[7]     = on;
    return w;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    expQ.push_back('{exp: e, tag: tag});
    -> sampleEv;
    wait (expQ.size() == 0);
  endtask

  task automatic pulseLink(input int lane, input int evt, input int n);
    @(negedge clk);
    dllpEvt[lane*7+evt] = 1'b1;
    repeat (n) @(negedge clk);
    dllpEvt = '0;
  endtask

  task automatic pulseTrans(input int lane, input int evt, input int n);
    @(negedge clk);
    tlpEvt[lane*24+evt] = 1'b1;
    repeat (n) @(negedge clk);
    tlpEvt = '0;
  endtask

  task automatic pulseAll(input int n);
    @(negedge clk);
    dllpEvt = '1; tlpEvt = '1;
    repeat (n) @(negedge clk);
    dllpEvt = '0; tlpEvt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h08, 32'h0, "R1 ctrl after reset");
    rd(8'h0C, 32'h0, "R1 count after reset");

    // R2 selection stored, no command effect
    wr(8'h08, ctl(6, 2, 1, 0, 0));
    rd(8'h08, view(6, 2, 1, 0), "R2 selection readback");

    // R3 on, R4/R5 counting link event lane1 evt2
    wr(8'h08, ctl(6, 2, 1, 3, 1));
    rd(8'h08, view(6, 2, 1, 1), "R3 status bit on");
    pulseLink(1, 2, 5);
    rd(8'h0C, 32'd5, "R4 R5 link count");

    // R6 neighbours do not count
    pulseLink(0, 2, 3);
    pulseLink(1, 3, 3);
    pulseTrans(1, 2, 3);
    rd(8'h0C, 32'd5, "R6 neighbours ignored");

    // R3 other codes keep state; R8 other clear codes keep count
    wr(8'h08, ctl(6, 2, 1, 5, 2));
    rd(8'h08, view(6, 2, 1, 1), "R3 code 5 keeps on");
    rd(8'h0C, 32'd5, "R8 clear code 2 ignored");

    // R3 off, R8 count retained
    wr(8'h08, ctl(6, 2, 1, 1, 0));
    pulseLink(1, 2, 4);
    rd(8'h08, view(6, 2, 1, 0), "R3 status bit off");
    rd(8'h0C, 32'd5, "R8 count kept while off");

    // R5 transaction group, last event
    wr(8'h08, ctl(7, 23, 2, 3, 1));
    pulseTrans(2, 23, 7);
    pulseTrans(2, 22, 2);
    rd(8'h0C, 32'd7, "R5 trans lane2 evt23");

    // R6 unsupported event / group
    wr(8'h08, ctl(6, 7, 0, 3, 1));
    pulseAll(3);
    rd(8'h0C, 32'd0, "R6 link event 7 unmapped");
    wr(8'h08, ctl(3, 0, 0, 3, 1));
    pulseAll(3);
    rd(8'h0C, 32'd0, "R6 group 3 unmapped");

    // R7 lane beyond NUM_LANES
    wr(8'h08, ctl(7, 0, 3, 3, 1));
    pulseAll(4);
    rd(8'h0C, 32'd0, "R7 lane 3 no match");
    wr(8'h08, ctl(6, 0, 15, 3, 1));
    pulseAll(4);
    rd(8'h0C, 32'd0, "R7 lane 15 no match");

    // R9 clear and pulse in the same cycle
    wr(8'h08, ctl(7, 1, 0, 3, 1));
    pulseTrans(0, 1, 4);
    rd(8'h0C, 32'd4, "R9 pre-count");
    @(negedge clk);
    tlpEvt[1] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'h08; regWrData = ctl(7, 1, 0, 3, 1);
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; tlpEvt = '0;
    rd(8'h0C, 32'd0, "R9 clear wins over pulse");
    pulseTrans(0, 1, 1);
    rd(8'h0C, 32'd1, "R9 counting resumes");

    // R10 wrap
    wr(8'h08, ctl(7, 5, 1, 3, 1));
    pulseTrans(1, 5, 255);
    rd(8'h0C, 32'd255, "R10 at maximum");
    pulseTrans(1, 5, 1);
    rd(8'h0C, 32'd0, "R10 wrapped to zero");
    pulseTrans(1, 5, 2);
    rd(8'h0C, 32'd2, "R10 counts after wrap");

    // R11 other offsets
    rd(8'h10, 32'd0, "R11 unmapped read");
    wr(8'h04, ctl(6, 0, 0, 1, 1));
    rd(8'h08, view(7, 5, 1, 1), "R11 stray write ctrl");
    rd(8'h0C, 32'd2, "R11 stray write count");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule